// File: doc/BRIEF.md
# Signed Long Divider

This block divides a 32-bit two's-complement dividend by a 16-bit two's-complement divisor. It returns a 16-bit quotient rounded toward zero, a 16-bit remainder, and an overflow flag. It is meant for the integer execution stage of a 16-bit processor. The core never turns the operands into magnitudes first. It runs a four-quadrant non-restoring recurrence in which each step picks the add or subtract direction from the signs of the partial remainder and the divisor. A single correction step then gives the remainder the sign of the dividend.

The operand −32768 gets special treatment. A divisor of −32768 combined with a dividend whose low half is zero is resolved exactly at setup. The coarse sign screen on the dividend is not applied when the divisor is −32768. Overflow is detected in three places:
- a sign screen at setup;
- a magnitude probe that stands in for the first divide step;
- a range check after correction.

Any division whose true quotient is −32768 therefore finishes cleanly.

Latency is counted in rising clock edges. The edge that samples `start` is edge 1, and `done` is high after edge N.

Top module: `sdiv_long`

## Requirements
- R1: When the true quotient fits in −32768..32767 and the divisor is nonzero, `quotient` equals dividend/divisor truncated toward zero, `remainder` equals dividend − quotient·divisor, and `overflow` is 0.
- R2: With `overflow` at 0, the remainder is zero or has the sign of the dividend, and its magnitude is less than that of the divisor.
- R3: `overflow` is 1 exactly when the divisor is zero or the true quotient lies outside −32768..32767. Quotient and remainder carry no meaning in that case.
- R4: A zero divisor gives `overflow`=1 with `done` after edge 3, without iterating.
- R5: Every division whose true quotient is −32768 completes with `overflow`=0. This includes dividends of 2^30+n divided by −32768, where dividend bits 31 and 30 differ.
- R6: For a divisor of 0x8000 and dividend bits 15:0 all zero, the result comes after edge 3. The quotient is −2·(dividend bits 31:16), the remainder is 0, and `overflow` is raised only when that quotient is out of range.
- R7: For a divisor that is nonzero and not 0x8000, with dividend bits 31 and 30 differing, `overflow`=1 with `done` after edge 3.
- R8: Otherwise, when |dividend| ≥ |divisor|·65536, `overflow`=1 with `done` after edge 4.
- R9: Every other division takes 16 iterations and finishes after edge 21. A quotient that leaves the 16-bit range there is flagged by the range check after correction, for example a positive result where the signs call for a negative one.
- R10: `done` is a one-cycle pulse, and `busy` is low whenever `done` is high. A `start` while `busy` is high has no effect on the running result and adds no `done`. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands and begin, honoured only when idle |
| dividend | input | 32 | Two's-complement dividend |
| divisor | input | 16 | Two's-complement divisor |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse, results valid |
| quotient | output | 16 | Quotient, registered at `done` |
| remainder | output | 16 | Remainder, registered at `done` |
| overflow | output | 1 | Quotient not representable or divisor zero |

## Verification
Several cases are hard to reach with random 32-bit operands because they almost never occur that way:
- an exact quotient of −32768;
- the exact-multiple case with divisor 0x8000;
- results just outside the range that slip past both early screens.

The stimulus builds such operands on purpose. It places dividends around 2^30 and −2^31, and around ±65536 for small divisors. It also draws random quotient, divisor and remainder triples and multiplies them back into a dividend, so that most runs travel the full iteration path. A second start is driven during the setup cycle of selected divisions to show that it is ignored.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_PROBE,
    S_ITER,
    S_CORR,
    S_CHECK
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_screen.sv
// Setup-time screens: zero divisor, exact most-negative case, sign screen.
module sdiv_screen #(
  parameter int DW = 16
) (
  input  logic [2*DW-1:0]        dvd,
  input  logic [DW-1:0]          dvs,
  output logic                   zero_dvs,
  output logic                   exact_hit,
  output logic                   sign_abort,
  output logic signed [DW+1:0]   exact_quo
);
  localparam int XW = 2 * DW;
  localparam int QW = DW + 2;
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  logic                 mostneg;
  logic signed [QW-1:0] hi_twice;

  always_comb begin
    mostneg    = (dvs == MOST_NEG);
    zero_dvs   = (dvs == '0);
    exact_hit  = mostneg && (dvd[DW-1:0] == '0);
    // top two dividend bits must agree unless the divisor is most negative
    sign_abort = !mostneg && (dvd[XW-1] != dvd[XW-2]);
    // dividend = H * 2^DW, divisor = -2^(DW-1)  ->  quotient = -2H
    hi_twice   = {dvd[XW-1], dvd[XW-1:DW], 1'b0};
    exact_quo  = -hi_twice;
  end
endmodule

// File: rtl/sdiv_probe.sv
// Magnitude probe standing in for the first divide step:
// flags |dividend| >= |divisor| * 2^DW.
module sdiv_probe #(
  parameter int DW = 16
) (
  input  logic [2*DW-1:0] dvd,
  input  logic [DW-1:0]   dvs,
  output logic            too_big
);
  localparam int XW = 2 * DW;
  localparam int RW = 2 * DW + 2;

  logic signed [RW-1:0] dd_x;
  logic signed [RW-1:0] ds_x;
  logic signed [RW-1:0] trial;

  always_comb begin
    dd_x  = {{(RW-XW){dvd[XW-1]}}, dvd};
    ds_x  = {{2{dvs[DW-1]}}, dvs, {DW{1'b0}}};
    trial = (dvd[XW-1] == dvs[DW-1]) ? (dd_x - ds_x) : (dd_x + ds_x);
    if (dvd[XW-1]) too_big = trial[RW-1] || (trial == '0);
    else           too_big = !trial[RW-1];
  end
endmodule

// File: rtl/sdiv_step.sv
// One four-quadrant non-restoring step.
module sdiv_step #(
  parameter int DW = 16
) (
  input  logic signed [2*DW+1:0] part_in,
  input  logic signed [2*DW+1:0] dvs_aligned,
  output logic signed [2*DW+1:0] part_out,
  output logic                   qbit
);
  localparam int RW = 2 * DW + 2;

  always_comb begin
    // same sign (zero counted as positive): move down by the divisor, digit +1
    qbit     = (part_in[RW-1] == dvs_aligned[RW-1]);
    part_out = qbit ? (part_in - dvs_aligned) : (part_in + dvs_aligned);
  end
endmodule

// File: rtl/sdiv_fixup.sv
// Correction: remainder to the dividend's sign and below |divisor|.
module sdiv_fixup #(
  parameter int DW = 16
) (
  input  logic signed [2*DW+1:0] part,
  input  logic signed [DW+1:0]   quo_raw,
  input  logic                   dvd_neg,
  input  logic [DW-1:0]          dvs,
  output logic signed [2*DW+1:0] part_fix,
  output logic signed [DW+1:0]   quo_fix
);
  localparam int RW = 2 * DW + 2;
  localparam int QW = DW + 2;
  localparam logic signed [QW-1:0] ONE = QW'(1);

  logic signed [RW-1:0] dx;

  always_comb begin
    dx       = {{(RW-DW){dvs[DW-1]}}, dvs};
    part_fix = part;
    quo_fix  = quo_raw;
    if (part != '0) begin
      if (part[RW-1] != dvd_neg) begin
        if (part[RW-1] == dvs[DW-1]) begin
          part_fix = part - dx;
          quo_fix  = quo_raw + ONE;
        end else begin
          part_fix = part + dx;
          quo_fix  = quo_raw - ONE;
        end
      end else if (part == dx) begin
        part_fix = '0;
        quo_fix  = quo_raw + ONE;
      end else if (part == -dx) begin
        part_fix = '0;
        quo_fix  = quo_raw - ONE;
      end
    end
  end
endmodule

// File: rtl/sdiv_long.sv
module sdiv_long #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2*DW-1:0] dividend,
  input  logic [DW-1:0]   divisor,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   quotient,
  output logic [DW-1:0]   remainder,
  output logic            overflow
);
  import sdiv_pkg::*;

  localparam int XW = 2 * DW;
  localparam int RW = 2 * DW + 2;
  localparam int QW = DW + 2;
  localparam int CW = $clog2(DW);
  localparam logic signed [QW-1:0] Q_MAX    = QW'(2**(DW-1) - 1);
  localparam logic signed [QW-1:0] Q_MIN    = ~Q_MAX;
  localparam logic signed [QW-1:0] Q_OFFSET = QW'(2**DW);

  sdiv_state_e          state;
  logic [XW-1:0]        dvd_q;
  logic [DW-1:0]        dvs_q;
  logic signed [RW-1:0] part_q;
  logic signed [RW-1:0] dsh_q;
  logic [DW-1:0]        pbits_q;
  logic [CW-1:0]        cnt_q;
  logic signed [QW-1:0] qacc_q;
  logic                 v_pend_q;
  logic                 busy_q, done_q, ovf_q;
  logic [DW-1:0]        quo_q, rem_q;

  logic                 zero_dvs, exact_hit, sign_abort, too_big, qbit;
  logic signed [QW-1:0] exact_quo, q_raw, fix_q;
  logic signed [RW-1:0] step_out, fix_r;
  logic                 rem_fits, out_of_range;

  sdiv_screen #(.DW(DW)) u_screen (
    .dvd(dvd_q), .dvs(dvs_q), .zero_dvs(zero_dvs), .exact_hit(exact_hit),
    .sign_abort(sign_abort), .exact_quo(exact_quo)
  );

  sdiv_probe #(.DW(DW)) u_probe (
    .dvd(dvd_q), .dvs(dvs_q), .too_big(too_big)
  );

  sdiv_step #(.DW(DW)) u_step (
    .part_in(part_q), .dvs_aligned(dsh_q), .part_out(step_out), .qbit(qbit)
  );

  // digits +1/-1 recoded: Q = 2P + 1 - 2^DW
  assign q_raw = $signed({1'b0, pbits_q, 1'b1}) - Q_OFFSET;

  sdiv_fixup #(.DW(DW)) u_fixup (
    .part(part_q), .quo_raw(q_raw), .dvd_neg(dvd_q[XW-1]), .dvs(dvs_q),
    .part_fix(fix_r), .quo_fix(fix_q)
  );

  always_comb begin
    rem_fits     = (part_q == {{(RW-DW){part_q[DW-1]}}, part_q[DW-1:0]});
    out_of_range = (qacc_q > Q_MAX) || (qacc_q < Q_MIN) || !rem_fits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      dvd_q    <= '0;
      dvs_q    <= '0;
      part_q   <= '0;
      dsh_q    <= '0;
      pbits_q  <= '0;
      cnt_q    <= '0;
      qacc_q   <= '0;
      v_pend_q <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
      quo_q    <= '0;
      rem_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            dvd_q    <= dividend;
            dvs_q    <= divisor;
            v_pend_q <= 1'b0;
            busy_q   <= 1'b1;
            state    <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (zero_dvs) begin
            v_pend_q <= 1'b1;
            qacc_q   <= '0;
            part_q   <= '0;
            state    <= S_CHECK;
          end else if (exact_hit) begin
            qacc_q <= exact_quo;
            part_q <= '0;
            state  <= S_CHECK;
          end else if (sign_abort) begin
            v_pend_q <= 1'b1;
            qacc_q   <= '0;
            part_q   <= '0;
            state    <= S_CHECK;
          end else begin
            part_q <= {{(RW-XW){dvd_q[XW-1]}}, dvd_q};
            state  <= S_PROBE;
          end
        end
        S_PROBE: begin
          if (too_big) begin
            v_pend_q <= 1'b1;
            qacc_q   <= '0;
            part_q   <= '0;
            state    <= S_CHECK;
          end else begin
            dsh_q   <= {{3{dvs_q[DW-1]}}, dvs_q, {(DW-1){1'b0}}};
            pbits_q <= '0;
            cnt_q   <= CW'(DW - 1);
            state   <= S_ITER;
          end
        end
        S_ITER: begin
          part_q  <= step_out;
          pbits_q <= {pbits_q[DW-2:0], qbit};
          dsh_q   <= dsh_q >>> 1;
          if (cnt_q == '0) state <= S_CORR;
          else             cnt_q <= cnt_q - 1'b1;
        end
        S_CORR: begin
          part_q <= fix_r;
          qacc_q <= fix_q;
          state  <= S_CHECK;
        end
        S_CHECK: begin
          quo_q  <= qacc_q[DW-1:0];
          rem_q  <= part_q[DW-1:0];
          ovf_q  <= v_pend_q || out_of_range;
          done_q <= 1'b1;
          busy_q <= 1'b0;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign overflow  = ovf_q;

  logic [DW:0] rem_mag, dvs_mag;
  always_comb begin
    rem_mag = rem_q[DW-1] ? ((DW+1)'(0) - {1'b1, rem_q}) : {1'b0, rem_q};
    dvs_mag = dvs_q[DW-1] ? ((DW+1)'(0) - {1'b1, dvs_q}) : {1'b0, dvs_q};
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(dvs_q) && $stable(dvd_q))); // R10
  AST_ZERO_DIV_OVF: assert property (@(posedge clk) disable iff (rst)
    (done && dvs_q == '0) |-> overflow); // R4
  AST_REM_SIGN: assert property (@(posedge clk) disable iff (rst)
    (done && !overflow && remainder != '0) |-> (remainder[DW-1] == dvd_q[XW-1])); // R2
  AST_REM_SMALL: assert property (@(posedge clk) disable iff (rst)
    (done && !overflow) |-> (rem_mag < dvs_mag)); // R2
  AST_EXACT_ZERO_REM: assert property (@(posedge clk) disable iff (rst)
    (done && !overflow && dvs_q == {1'b1, {(DW-1){1'b0}}} && dvd_q[DW-1:0] == '0)
      |-> (remainder == '0)); // R6
endmodule

// File: tb/sdiv_long_bench.sv
module sdiv_long_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, overflow;
  logic [15:0] quotient, remainder;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit pulse_chk = 1'b0;
  bit ended = 1'b0;

  typedef struct packed {
    logic [31:0] dd;
    logic [15:0] dr;
    logic        v;
    logic [15:0] q;
    logic [15:0] r;
    logic [31:0] t0;
    logic [7:0]  lat;
  } exp_t;

  exp_t  sb_q[$];
  string vtag_q[$];
  string ltag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdiv_long u_sdiv_long (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .overflow(overflow)
  );

  function automatic longint labs(input longint x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic void ref_div(input logic [31:0] dd, input logic [15:0] dr,
                                  output logic v, output logic [15:0] q,
                                  output logic [15:0] r);
    longint a, b, qq, rr;
    a = longint'($signed(dd));
    b = longint'($signed(dr));
    if (b == 0) begin
      v = 1'b1; q = '0; r = '0;
    end else begin
      qq = a / b;
      rr = a % b;
      v  = (qq > 32767) || (qq < -32768);
      q  = qq[15:0];
      r  = rr[15:0];
    end
  endfunction

  function automatic int exp_lat(input logic [31:0] dd, input logic [15:0] dr,
                                 output string tag);
    longint a, b;
    a = longint'($signed(dd));
    b = longint'($signed(dr));
    if (dr == 16'h0000) begin tag = "R4"; return 3; end
    if (dr == 16'h8000 && dd[15:0] == 16'h0000) begin tag = "R6"; return 3; end
    if (dr != 16'h8000 && dd[31] != dd[30]) begin tag = "R7"; return 3; end
    if (labs(a) >= labs(b) * 65536) begin tag = "R8"; return 4; end
    tag = "R9";
    return 21;
  endfunction

  task automatic go(input logic [31:0] dd, input logic [15:0] dr,
                    input string vt, input bit inject);
    exp_t  e;
    string lt;
    logic  v;
    logic [15:0] q, r;
    while (sb_q.size() != 0 || busy) @(negedge clk);
    ref_div(dd, dr, v, q, r);
    e.dd  = dd;
    e.dr  = dr;
    e.v   = v;
    e.q   = q;
    e.r   = r;
    e.t0  = cyc;
    e.lat = 8'(exp_lat(dd, dr, lt));
    sb_q.push_back(e);
    vtag_q.push_back(vt);
    ltag_q.push_back(lt);
    dividend = dd;
    divisor  = dr;
    start    = 1'b1;
    @(negedge clk);
    if (inject) begin
      dividend = ~dd;
      divisor  = dr ^ 16'h5a5a;
      @(negedge clk);
    end
    start    = 1'b0;
    dividend = $urandom;
    divisor  = 16'($urandom);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !ended) begin
      if (pulse_chk) begin
        checks++;
        if (done) begin
          fails++;
          $display("FAIL R10 done wider than one cycle: actual=1 expected=0");
        end
        pulse_chk = 1'b0;
      end else if (done) begin
        if (sb_q.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R10 unexpected done: actual=1 expected=0");
        end else begin
          exp_t  e;
          string vt, lt;
          int    lat;
          logic [16:0] rmag, dmag;
          e  = sb_q.pop_front();
          vt = vtag_q.pop_front();
          lt = ltag_q.pop_front();
          checks++;
          if (overflow !== e.v) begin
            fails++;
            $display("FAIL %s/R3 overflow %h/%h: actual=%0b expected=%0b",
                     vt, e.dd, e.dr, overflow, e.v);
          end
          if (!e.v) begin
            checks++;
            if (quotient !== e.q || remainder !== e.r) begin
              fails++;
              $display("FAIL %s/R1 %h/%h: actual q=%h r=%h expected q=%h r=%h",
                       vt, e.dd, e.dr, quotient, remainder, e.q, e.r);
            end
            checks++;
            rmag = remainder[15] ? 17'(0) - {1'b1, remainder} : {1'b0, remainder};
            dmag = e.dr[15] ? 17'(0) - {1'b1, e.dr} : {1'b0, e.dr};
            if ((remainder != 16'h0 && remainder[15] != e.dd[31]) || rmag >= dmag) begin
              fails++;
              $display("FAIL R2 remainder form %h/%h: actual r=%h expected sign=%0b below %h",
                       e.dd, e.dr, remainder, e.dd[31], dmag);
            end
          end
          checks++;
          lat = cyc - int'(e.t0);
          if (lat != int'(e.lat)) begin
            fails++;
            $display("FAIL %s latency %h/%h: actual=%0d expected=%0d",
                     lt, e.dd, e.dr, lat, e.lat);
          end
          pulse_chk = 1'b1;
        end
      end
    end
  end

  task automatic summary();
    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R10
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || overflow !== 1'b0 ||
        quotient !== 16'h0 || remainder !== 16'h0) begin
      fails++;
      $display("FAIL R10 reset: actual busy=%b done=%b v=%b q=%h r=%h expected all zero",
               busy, done, overflow, quotient, remainder);
    end
    rst = 1'b0;
    @(negedge clk);

    // R5: quotient exactly -32768
    go(32'h4000_0000, 16'h8000, "R5", 1'b0);
    go(32'h4000_0005, 16'h8000, "R5", 1'b1);
    go(32'hFFFF_0000, 16'h0002, "R5", 1'b0);
    go(32'h0001_8000, 16'hFFFD, "R5", 1'b0);
    go(32'hFFFE_FFFF, 16'h0002, "R5", 1'b1);
    // R6: exact multiples by the most negative divisor
    go(32'hC000_0000, 16'h8000, "R6", 1'b0);
    go(32'h8000_0000, 16'h8000, "R6", 1'b0);
    go(32'h3FFF_0000, 16'h8000, "R6", 1'b0);
    go(32'hFFFF_0000, 16'h8000, "R6", 1'b1);
    // R7 sign screen
    go(32'h8000_0000, 16'h0001, "R7", 1'b0);
    go(32'h7FFF_FFFF, 16'hFFFF, "R7", 1'b1);
    go(32'h4000_0000, 16'h7FFF, "R7", 1'b0);
    // R8 magnitude probe
    go(32'h0001_0000, 16'h0001, "R8", 1'b0);
    go(32'hFFFF_0000, 16'hFFFF, "R8", 1'b1);
    // R4 zero divisor
    go(32'd123, 16'h0000, "R4", 1'b0);
    go(32'h8000_0000, 16'h0000, "R4", 1'b1);
    // R9 / R3 late range check
    go(32'h0001_0000, 16'h0002, "R9", 1'b0);
    go(32'hFFFF_8000, 16'hFFFF, "R9", 1'b0);
    go(32'h0000_FFFF, 16'hFFFF, "R9", 1'b0);
    // R1 / R2 sign quadrants and edges
    go(32'h0, 16'hFFFF, "R1", 1'b0);
    go(32'd1073709055, 16'h7FFF, "R1", 1'b0);
    go(32'hFFFF_FFFF, 16'h8000, "R2", 1'b0);
    go(32'h3FFF_FFFF, 16'h8000, "R2", 1'b0);
    go(32'd7, 16'd2, "R2", 1'b0);
    go(-32'sd7, 16'd2, "R2", 1'b0);
    go(32'd7, -16'sd2, "R2", 1'b0);
    go(-32'sd7, -16'sd2, "R2", 1'b0);
    go(-32'sd6, 16'd3, "R2", 1'b0);
    go(-32'sd6, -16'sd3, "R2", 1'b1);

    for (int i = 0; i < 1200; i++) begin
      logic [31:0] dd;
      logic [15:0] dr;
      longint qv, dv, rv, prod;
      case ($urandom_range(0, 3))
        0: begin
          qv = longint'($signed(16'($urandom)));
          dv = longint'($signed(16'($urandom)));
          if (dv == 0) dv = 1;
          prod = qv * dv;
          rv = longint'($urandom_range(0, 32767)) % labs(dv);
          if (prod < 0 || (prod == 0 && $urandom_range(0, 1) == 1)) rv = -rv;
          dd = 32'(prod + rv);
          dr = 16'(dv);
        end
        1: begin
          dd = $urandom;
          dr = 16'($urandom);
        end
        2: begin
          dd = {{8{1'b0}}, 24'($urandom)};
          if ($urandom_range(0, 1) == 1) dd = -dd;
          dr = 16'($urandom);
        end
        default: begin
          dd = $urandom;
          if ($urandom_range(0, 1) == 1) dd[15:0] = 16'h0;
          dr = 16'h8000;
        end
      endcase
      go(dd, dr, "R1", (i % 7) == 3);
    end

    while (sb_q.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule